// File: doc/BRIEF.md
# Multi-Mode Macrocell Register

This block is the storage and output-selection stage of one programmable logic cell. A static configuration word turns its single storage bit into a D, T, JK or SR flip-flop, or into a transparent latch. The same word picks where the data comes from: the cell's combinational logic result, a spare product term, or the pin input. It picks the clock (one of three global clocks or a product term) and an optional clock enable. It picks the sources of the asynchronous clear and set. Two more bits decide, each on its own, whether the pin path and the buried feedback path carry the stored bit or the combinational result.

The block is written for a fabric that runs from one fast system clock. The macro clocks, the enable and the clear/set terms are plain inputs that are sampled on every system edge. A macro clock edge is a sample that is high where the sample before it was low. A clear or set acts on the next system edge, whatever the macro clock is doing. Both outputs are registered, so every output is a function of the inputs and state at the preceding system edge.

Top module: `mc_macro_reg`

## Requirements
- R1: With mode code 0 (D; the unused codes 5 to 7 also act as D), the state takes the selected data on a macro clock rising edge. A rising edge is a sample of 1 whose previous system-clock sample was 0. In every flip-flop mode the state holds on all other cycles.
- R2: With mode code 1 (T), a rising edge with data 1 inverts the state, and a rising edge with data 0 leaves it unchanged.
- R3: With mode code 2 (JK), J is pt_a_i and K is pt_b_i. On a rising edge 00 holds, 10 sets, 01 clears and 11 toggles.
- R4: With mode code 3 (SR), S is pt_a_i and R is pt_b_i. On a rising edge 10 sets, 01 clears, and 00 and 11 both hold.
- R5: With mode code 4 (latch), the state follows the data on every system edge at which the selected clock sample is high (and the enable permits). While that sample is low, the state holds.
- R6: The data source field cfg_i[4:3] selects 0 = comb_i, 1 = the data term, 2 = pin_i, 3 = comb_i. The data term is pt_a_i when cfg_i[11]=0 and pt_b_i when cfg_i[11]=1.
- R7: The clock source field cfg_i[6:5] selects global clocks 0 to 2 (gclk_i[n]) or, with code 3, the clock term. The clock term is pt_a_i when cfg_i[12]=0 and pt_b_i when it is 1. Edges on unselected clocks have no effect.
- R8: When cfg_i[7]=1 and a global clock is selected, the enable term gates the clock. The enable term is pt_a_i when cfg_i[13]=0 and pt_b_i when it is 1. While the enable is 0, rising edges, and latch transparency, are ignored. With the term clock selected, the enable has no effect.
- R9: The clear field cfg_i[9:8] selects 0 = none, 1 = gclr_i, 2 = the clear term, 3 = gclr_i OR the clear term. The clear term is pt_a_i when cfg_i[14]=0 and pt_b_i when it is 1. An active clear forces the state to 0 at the next system edge, whatever the clock is doing.
- R10: When cfg_i[10]=1, the set term forces the state to 1 at the next system edge. The set term is pt_a_i when cfg_i[15]=0 and pt_b_i when it is 1. When clear and set are active together, the state goes to 0.
- R11: With cfg_i[16]=1, pin_o carries the new state one system cycle after the edge. With cfg_i[16]=0, pin_o carries comb_i from the preceding edge.
- R12: cfg_i[17] makes the same choice for fb_o, independently of cfg_i[16].
- R13: While rst_i is high at a system edge, the state, pin_o and fb_o become 0, and the stored clock samples become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cfg_i | input | 18 | Static configuration word |
| comb_i | input | 1 | Combinational logic result of the cell |
| pt_a_i | input | 1 | First spare product term |
| pt_b_i | input | 1 | Second spare product term |
| pin_i | input | 1 | Pin input value |
| gclk_i | input | 3 | Global macro clocks |
| gclr_i | input | 1 | Global clear |
| pin_o | output | 1 | Pin-path value |
| fb_o | output | 1 | Buried feedback value |

## Verification
The hardest case to reach is a rising edge that must be ignored because the enable term is low, combined with each register mode. The same applies to a clear or set that arrives between macro clock edges while the state is about to toggle or load. The two spare terms also serve as data, J/K or S/R, enable, clear and set. Because of this, the bench sweeps every mode, data source, clock source, enable, clear and set choice and both output selections. It draws the term selections and all per-cycle inputs at random, so that these overlaps occur many times in every configuration. A bench model built from the requirements predicts both outputs on every cycle.

// File: rtl/mc_pkg.sv
package mc_pkg;

  localparam int unsigned MC_NUM_GCLK = 3;
  localparam int unsigned MC_CSRC_W   = $clog2(MC_NUM_GCLK + 1);
  localparam int unsigned MC_MODE_W   = 3;

  typedef enum logic [MC_MODE_W-1:0] {
    MODE_D     = 3'd0,
    MODE_T     = 3'd1,
    MODE_JK    = 3'd2,
    MODE_SR    = 3'd3,
    MODE_LATCH = 3'd4
  } reg_mode_e;

  typedef enum logic [1:0] {
    DSRC_LOGIC = 2'd0,
    DSRC_TERM  = 2'd1,
    DSRC_PIN   = 2'd2,
    DSRC_ALT   = 2'd3
  } dsrc_e;

  typedef enum logic [1:0] {
    CLR_OFF    = 2'd0,
    CLR_GLOBAL = 2'd1,
    CLR_TERM   = 2'd2,
    CLR_BOTH   = 2'd3
  } clr_src_e;

  // Packed MSB first; bit 0 is mode[0].
  typedef struct packed {
    logic                  fb_reg;     // 17
    logic                  pin_reg;    // 16
    logic                  set_tsel;   // 15
    logic                  clr_tsel;   // 14
    logic                  en_tsel;    // 13
    logic                  clk_tsel;   // 12
    logic                  dat_tsel;   // 11
    logic                  set_en;     // 10
    logic [1:0]            clr_src;    // 9:8
    logic                  ce_en;      // 7
    logic [MC_CSRC_W-1:0]  csrc;       // 6:5
    logic [1:0]            dsrc;       // 4:3
    logic [MC_MODE_W-1:0]  mode;       // 2:0
  } mc_cfg_t;

  localparam int unsigned MC_CFG_W = $bits(mc_cfg_t);

endpackage

// File: rtl/mc_term_route.sv
module mc_term_route
  import mc_pkg::*;
#(
  parameter int unsigned NUM_GCLK = MC_NUM_GCLK,
  localparam int unsigned CSRC_W  = $clog2(NUM_GCLK + 1)
) (
  input  logic              comb_i,
  input  logic              pt_a_i,
  input  logic              pt_b_i,
  input  logic              pin_i,
  input  logic              gclr_i,
  input  logic [1:0]        dsrc_i,
  input  logic [CSRC_W-1:0] csrc_i,
  input  logic              ce_en_i,
  input  logic [1:0]        clr_src_i,
  input  logic              set_en_i,
  input  logic              dat_tsel_i,
  input  logic              clk_tsel_i,
  input  logic              en_tsel_i,
  input  logic              clr_tsel_i,
  input  logic              set_tsel_i,
  output logic              data_o,
  output logic              clk_term_o,
  output logic              en_o,
  output logic              clr_o,
  output logic              set_o
);

  logic dat_term, en_term, clr_term, set_term;
  logic term_clk_sel;

  assign dat_term   = dat_tsel_i ? pt_b_i : pt_a_i;
  assign clk_term_o = clk_tsel_i ? pt_b_i : pt_a_i;
  assign en_term    = en_tsel_i  ? pt_b_i : pt_a_i;
  assign clr_term   = clr_tsel_i ? pt_b_i : pt_a_i;
  assign set_term   = set_tsel_i ? pt_b_i : pt_a_i;

  assign term_clk_sel = (csrc_i == CSRC_W'(NUM_GCLK));

  always_comb begin
    unique case (dsrc_e'(dsrc_i))
      DSRC_TERM: data_o = dat_term;
      DSRC_PIN:  data_o = pin_i;
      default:   data_o = comb_i;
    endcase
  end

  // Enable only gates the global clocks.
  assign en_o = (ce_en_i && !term_clk_sel) ? en_term : 1'b1;

  always_comb begin
    unique case (clr_src_e'(clr_src_i))
      CLR_GLOBAL: clr_o = gclr_i;
      CLR_TERM:   clr_o = clr_term;
      CLR_BOTH:   clr_o = gclr_i | clr_term;
      default:    clr_o = 1'b0;
    endcase
  end

  assign set_o = set_en_i & set_term;

endmodule

// File: rtl/mc_clk_sense.sv
module mc_clk_sense #(
  parameter int unsigned NUM_SRC = 4,
  localparam int unsigned SEL_W  = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               lvl_o,
  output logic               rise_o
);

  logic [NUM_SRC-1:0] prev_vec;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_prev
    logic smp_q;
    always_ff @(posedge clk_i) begin
      if (rst_i) smp_q <= 1'b0;
      else       smp_q <= src_i[g];
    end
    assign prev_vec[g] = smp_q;
  end

  assign lvl_o  = src_i[sel_i];
  assign rise_o = src_i[sel_i] & ~prev_vec[sel_i];

  // A detected edge leaves the stored sample high, so no edge can follow directly.
  AST_NO_BACK_TO_BACK_EDGE: assert property (@(posedge clk_i) disable iff (rst_i)
    (rise_o && $stable(sel_i)) |=> !rise_o) else $error("edge seen twice"); // R7

endmodule

// File: rtl/mc_next_state.sv
module mc_next_state
  import mc_pkg::*;
(
  input  logic [MC_MODE_W-1:0] mode_i,
  input  logic                 q_i,
  input  logic                 d_i,
  input  logic                 j_i,
  input  logic                 k_i,
  input  logic                 fire_i,
  input  logic                 open_i,
  input  logic                 clr_i,
  input  logic                 set_i,
  output logic                 nxt_o
);

  logic func_nxt;

  always_comb begin
    func_nxt = q_i;
    case (mode_i)
      MODE_T: begin
        if (fire_i && d_i) func_nxt = ~q_i;
      end
      MODE_JK: begin
        if (fire_i) begin
          case ({j_i, k_i})
            2'b10:   func_nxt = 1'b1;
            2'b01:   func_nxt = 1'b0;
            2'b11:   func_nxt = ~q_i;
            default: func_nxt = q_i;
          endcase
        end
      end
      MODE_SR: begin
        if (fire_i) begin
          case ({j_i, k_i})
            2'b10:   func_nxt = 1'b1;
            2'b01:   func_nxt = 1'b0;
            default: func_nxt = q_i;
          endcase
        end
      end
      MODE_LATCH: begin
        if (open_i) func_nxt = d_i;
      end
      default: begin
        if (fire_i) func_nxt = d_i;
      end
    endcase
  end

  // Clear outranks set; both outrank the clocked function.
  always_comb begin
    if (clr_i)      nxt_o = 1'b0;
    else if (set_i) nxt_o = 1'b1;
    else            nxt_o = func_nxt;
  end

endmodule

// File: rtl/mc_macro_reg.sv
module mc_macro_reg
  import mc_pkg::*;
#(
  parameter int unsigned NUM_GCLK = MC_NUM_GCLK,
  localparam int unsigned NUM_CSRC = NUM_GCLK + 1,
  localparam int unsigned CFG_W    = MC_CFG_W
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic [CFG_W-1:0]    cfg_i,
  input  logic                comb_i,
  input  logic                pt_a_i,
  input  logic                pt_b_i,
  input  logic                pin_i,
  input  logic [NUM_GCLK-1:0] gclk_i,
  input  logic                gclr_i,
  output logic                pin_o,
  output logic                fb_o
);

  mc_cfg_t cfg;
  assign cfg = mc_cfg_t'(cfg_i);

  logic data_sel, clk_term, en_sel, clr_act, set_act;
  logic clk_lvl, clk_rise, fire, open_lat;
  logic st_q, st_nxt, pin_q, fb_q;

  mc_term_route #(.NUM_GCLK(NUM_GCLK)) route_i (
    .comb_i    (comb_i),
    .pt_a_i    (pt_a_i),
    .pt_b_i    (pt_b_i),
    .pin_i     (pin_i),
    .gclr_i    (gclr_i),
    .dsrc_i    (cfg.dsrc),
    .csrc_i    (cfg.csrc),
    .ce_en_i   (cfg.ce_en),
    .clr_src_i (cfg.clr_src),
    .set_en_i  (cfg.set_en),
    .dat_tsel_i(cfg.dat_tsel),
    .clk_tsel_i(cfg.clk_tsel),
    .en_tsel_i (cfg.en_tsel),
    .clr_tsel_i(cfg.clr_tsel),
    .set_tsel_i(cfg.set_tsel),
    .data_o    (data_sel),
    .clk_term_o(clk_term),
    .en_o      (en_sel),
    .clr_o     (clr_act),
    .set_o     (set_act)
  );

  mc_clk_sense #(.NUM_SRC(NUM_CSRC)) sense_i (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .src_i ({clk_term, gclk_i}),
    .sel_i (cfg.csrc),
    .lvl_o (clk_lvl),
    .rise_o(clk_rise)
  );

  assign fire     = clk_rise & en_sel;
  assign open_lat = clk_lvl & en_sel;

  mc_next_state nxt_i (
    .mode_i(cfg.mode),
    .q_i   (st_q),
    .d_i   (data_sel),
    .j_i   (pt_a_i),
    .k_i   (pt_b_i),
    .fire_i(fire),
    .open_i(open_lat),
    .clr_i (clr_act),
    .set_i (set_act),
    .nxt_o (st_nxt)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st_q  <= 1'b0;
      pin_q <= 1'b0;
      fb_q  <= 1'b0;
    end else begin
      st_q  <= st_nxt;
      pin_q <= cfg.pin_reg ? st_nxt : comb_i;
      fb_q  <= cfg.fb_reg  ? st_nxt : comb_i;
    end
  end

  assign pin_o = pin_q;
  assign fb_o  = fb_q;

  AST_CLEAR_FORCES_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    clr_act |=> !st_q) else $error("clear ignored"); // R9
  AST_CLEAR_OVER_SET: assert property (@(posedge clk_i) disable iff (rst_i)
    (clr_act && set_act) |=> !st_q) else $error("set beat clear"); // R10
  AST_SET_FORCES_ONE: assert property (@(posedge clk_i) disable iff (rst_i)
    (set_act && !clr_act) |=> st_q) else $error("set ignored"); // R10
  AST_FLOP_HOLDS_NO_EDGE: assert property (@(posedge clk_i) disable iff (rst_i)
    (cfg.mode != MODE_LATCH && !fire && !clr_act && !set_act) |=> $stable(st_q))
    else $error("state moved without edge"); // R7
  AST_PIN_TRACKS_STATE: assert property (@(posedge clk_i) disable iff (rst_i)
    cfg.pin_reg |=> (pin_o == st_q)) else $error("pin path not registered"); // R11
  AST_FB_TRACKS_LOGIC: assert property (@(posedge clk_i) disable iff (rst_i)
    !cfg.fb_reg |=> (fb_o == $past(comb_i))) else $error("feedback not combinational"); // R12

endmodule

// File: tb/mc_macro_reg_tb_top.sv
`timescale 1ns/1ps
module mc_macro_reg_tb_top;
  import mc_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst;
  logic [MC_CFG_W-1:0] cfg;
  logic             comb, pta, ptb, pin, gclr;
  logic [2:0]       gclk;
  logic             pin_o, fb_o;

  mc_macro_reg dut_i (
    .clk_i(clk), .rst_i(rst), .cfg_i(cfg), .comb_i(comb), .pt_a_i(pta),
    .pt_b_i(ptb), .pin_i(pin), .gclk_i(gclk), .gclr_i(gclr),
    .pin_o(pin_o), .fb_o(fb_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  bit       m_st;
  bit [3:0] m_prev;

  task automatic chk(input bit act, input bit exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic run_cfg(input mc_cfg_t c, input int ncyc);
    bit e_pin, e_fb;
    string tag, ptag, ftag;
    @(negedge clk);
    rst = 1'b1; cfg = c; comb = 0; pta = 0; ptb = 0; pin = 0; gclk = 0; gclr = 0;
    @(negedge clk);
    chk(pin_o, 1'b0, "R13", "pin after reset");
    chk(fb_o,  1'b0, "R13", "fb after reset");
    m_st = 1'b0; m_prev = 4'b0;
    rst = 1'b0;
    for (int i = 0; i < ncyc; i++) begin
      bit ta, tb, d, dterm, cterm, eterm, rterm, sterm, lvl, rise, en, ar, ap, nxt;
      bit [3:0] cur;
      comb = $urandom % 2; pta = $urandom % 2; ptb = $urandom % 2;
      pin  = $urandom % 2; gclk = 3'($urandom % 8); gclr = ($urandom % 8) == 0;
      ta = pta; tb = ptb;
      dterm = c.dat_tsel ? tb : ta;
      cterm = c.clk_tsel ? tb : ta;
      eterm = c.en_tsel  ? tb : ta;
      rterm = c.clr_tsel ? tb : ta;
      sterm = c.set_tsel ? tb : ta;
      cur  = {cterm, gclk};
      lvl  = cur[c.csrc];
      rise = lvl && !m_prev[c.csrc];
      m_prev = cur;
      en = (c.ce_en && c.csrc != 2'd3) ? eterm : 1'b1;
      case (c.dsrc)
        2'd1: d = dterm;
        2'd2: d = pin;
        default: d = comb;
      endcase
      case (c.clr_src)
        2'd1: ar = gclr;
        2'd2: ar = rterm;
        2'd3: ar = gclr | rterm;
        default: ar = 1'b0;
      endcase
      ap = c.set_en & sterm;
      nxt = m_st;
      if (c.mode == 3'd4) begin
        if (lvl && en) nxt = d;
      end else if (rise && en) begin
        case (c.mode)
          3'd1: nxt = d ? !m_st : m_st;
          3'd2: nxt = (ta && tb) ? !m_st : (ta ? 1'b1 : (tb ? 1'b0 : m_st));
          3'd3: nxt = (ta && !tb) ? 1'b1 : ((!ta && tb) ? 1'b0 : m_st);
          default: nxt = d;
        endcase
      end
      if (ap) nxt = 1'b1;
      if (ar) nxt = 1'b0;
      if (ar)                   tag = "R9";
      else if (ap)              tag = "R10";
      else if (c.mode == 3'd4)  tag = "R5";
      else if (rise && !en)     tag = "R8";
      else if (!rise)           tag = "R7";
      else case (c.mode)
        3'd1: tag = "R2";
        3'd2: tag = "R3";
        3'd3: tag = "R4";
        default: tag = (c.dsrc != 2'd0) ? "R6" : "R1";
      endcase
      ptag = c.pin_reg ? tag : "R11";
      ftag = c.fb_reg  ? tag : "R12";
      e_pin = c.pin_reg ? nxt : comb;
      e_fb  = c.fb_reg  ? nxt : comb;
      m_st  = nxt;
      @(negedge clk);
      chk(pin_o, e_pin, ptag, $sformatf("pin cfg=%05h cyc=%0d", c, i));
      chk(fb_o,  e_fb,  ftag, $sformatf("fb cfg=%05h cyc=%0d", c, i));
    end
  endtask

  initial begin
    rst = 1'b1; cfg = '0; comb = 0; pta = 0; ptb = 0; pin = 0; gclk = 0; gclr = 0;
    repeat (2) @(negedge clk);
    for (int mo = 0; mo < 5; mo++)
      for (int ds = 0; ds < 3; ds++)
        for (int cs = 0; cs < 4; cs++)
          for (int ce = 0; ce < 2; ce++)
            for (int ar = 0; ar < 4; ar++)
              for (int ap = 0; ap < 2; ap++)
                for (int po = 0; po < 4; po++) begin
                  mc_cfg_t c;
                  c = '0;
                  c.mode = 3'(mo); c.dsrc = 2'(ds); c.csrc = 2'(cs);
                  c.ce_en = ce[0]; c.clr_src = 2'(ar); c.set_en = ap[0];
                  c.pin_reg = po[0]; c.fb_reg = po[1];
                  c.dat_tsel = $urandom % 2; c.clk_tsel = $urandom % 2;
                  c.en_tsel = $urandom % 2; c.clr_tsel = $urandom % 2;
                  c.set_tsel = $urandom % 2;
                  run_cfg(c, 16);
                end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion (R1 sweep)");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule